// File: doc/BRIEF.md
# Bus-Matching Write Packer

This block sits in front of the write side of a 36-bit FIFO and lets a narrower producer feed it. The producer's port can carry a full 36-bit long word, an 18-bit word or a 9-bit byte on each write. The width is chosen per write by a two-bit size code. In the narrow widths the block collects the pieces in holding registers. It raises a single 36-bit push toward the FIFO only in the same cycle that the last piece of a long word arrives. The FIFO therefore only ever receives complete long words.

An endian input chooses where the narrow piece sits on the input bus and in which order the long word is filled. A big-endian piece sits in the upper lanes and the word fills from the top lane downward. A little-endian piece sits in the lower lanes and the word fills from lane 0 upward. A two-bit swap code can reorder the four 9-bit lanes of the assembled word as it is pushed.

A write whose size differs from the last accepted FIFO write restarts the packing state, so any half-built word is thrown away. Size code 3 sends the write to a mailbox path instead. That path gets the raw bus with no swap, and the packer's state stays untouched. A full FIFO stalls only the write that would push; that write is refused and the block keeps its state until the write is offered again.

Top module: `bm_write_packer`

## Requirements
- R1: With size code 0 (long word), every write with `fifo_full` low raises `push` in the same cycle, and `push_data` is `wr_data` after the lane swap.
- R2: With size code 2 (byte), the first three accepted writes of a long word do not push. The fourth raises `push` in its own cycle with all four bytes, and after it packing starts again from an empty word.
- R3: With size code 1 (word), the first accepted write does not push. The second raises `push` in its own cycle with both words.
- R4: When `big_end` is 1, a byte is taken from bits 35:27 and a word from bits 35:18, and pieces fill the long word from the top lane down. When `big_end` is 0, a byte is taken from bits 8:0 and a word from bits 17:0, and pieces fill it from lane 0 (bits 8:0) up.
- R5: An accepted FIFO write whose size code differs from the previous accepted FIFO write discards any partial word and counts as the first piece of a new word. After reset, the previous size is taken to be long word.
- R6: In the narrow sizes, input lanes outside the selected piece have no effect on `push_data`.
- R7: With size code 3, the write is accepted, `mbox_wr` is high, `mbox_data` equals `wr_data` unswapped and `push` is low. The packing progress is unchanged, so the next FIFO piece continues the word in progress.
- R8: `push_data` lanes (lane i = bits 9i+8:9i) follow `swap_sel`: 0 keeps the order; 1 reverses all four lanes; 2 exchanges the two 18-bit halves; 3 exchanges the two lanes within each half.
- R9: A write that would complete a word while `fifo_full` is high is refused: `accept` and `push` stay low and the packing state is held. Non-final pieces are still accepted while the FIFO is full.
- R10: During and right after reset, `push`, `accept` and `mbox_wr` are low while `wr_en` is low. Reset also clears any partial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request from the narrow port |
| size_sel | input | 2 | 0 long word, 1 word, 2 byte, 3 mailbox |
| big_end | input | 1 | 1 selects big-endian lane placement and fill order |
| swap_sel | input | 2 | Lane reorder applied to pushed words |
| wr_data | input | 36 | Write data bus, four 9-bit lanes |
| fifo_full | input | 1 | FIFO cannot take a push this cycle |
| accept | output | 1 | The current write is taken |
| push | output | 1 | Push a complete long word into the FIFO |
| push_data | output | 36 | Long word pushed into the FIFO |
| mbox_wr | output | 1 | Write strobe toward the mailbox |
| mbox_data | output | 36 | Raw data toward the mailbox |

## Verification
`accept`, `push`, `push_data`, `mbox_wr` and `mbox_data` are combinational. They are due in the same cycle as the write that causes them. The piece count, the holding registers and the remembered size change on the rising edge that ends that cycle, so their effects appear on the next write. The bench drives each write just after a falling edge and samples every output 2 ns later, still inside that cycle. The following rising edge then commits the state that the next row of the table relies on.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 4;
  localparam int LONG_W = LANE_W * LANES;
  localparam int CNT_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_WORD = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_MBOX = 2'b11
  } size_e;

  typedef logic [LONG_W-1:0] long_t;
  typedef logic [LANES-1:0]  lmask_t;

  // pieces that make up one long word at a given size
  function automatic int pieces_for(size_e s);
    case (s)
      SZ_WORD: return 2;
      SZ_BYTE: return LANES;
      default: return 1;
    endcase
  endfunction

  function automatic int lanes_per(size_e s);
    return LANES / pieces_for(s);
  endfunction

  // lowest destination lane of piece idx
  function automatic int dst_low(size_e s, logic be, int idx);
    int per;
    per = lanes_per(s);
    return be ? (pieces_for(s) - 1 - idx) * per : idx * per;
  endfunction

  function automatic lmask_t piece_mask(size_e s, logic be, int idx);
    lmask_t m;
    int lo;
    int per;
    per = lanes_per(s);
    lo  = dst_low(s, be, idx);
    m   = '0;
    for (int l = 0; l < LANES; l++)
      if (l >= lo && l < lo + per) m[l] = 1'b1;
    return m;
  endfunction

  // moves the selected input lanes to their place in the long word
  function automatic long_t place_piece(long_t din, size_e s, logic be, int idx);
    long_t r;
    int per;
    int src;
    int dst;
    per = lanes_per(s);
    src = be ? LANES - per : 0;
    dst = dst_low(s, be, idx);
    r   = '0;
    for (int l = 0; l < LANES; l++)
      if (l < per) r[(dst + l) * LANE_W +: LANE_W] = din[(src + l) * LANE_W +: LANE_W];
    return r;
  endfunction

  function automatic long_t expand_mask(lmask_t m);
    long_t r;
    for (int l = 0; l < LANES; l++) r[l * LANE_W +: LANE_W] = {LANE_W{m[l]}};
    return r;
  endfunction

  // lane reorder: 0 none, 1 reverse, 2 swap halves, 3 swap within halves
  function automatic long_t swap_lanes(long_t w, logic [1:0] mode);
    long_t r;
    int src;
    for (int l = 0; l < LANES; l++) begin
      case (mode)
        2'd1:    src = LANES - 1 - l;
        2'd2:    src = l ^ (LANES / 2);
        2'd3:    src = l ^ 1;
        default: src = l;
      endcase
      r[l * LANE_W +: LANE_W] = w[src * LANE_W +: LANE_W];
    end
    return r;
  endfunction
endpackage

// File: rtl/bm_size_track.sv
module bm_size_track
  import bm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fifo_req,
  input  logic  take,
  input  size_e size_in,
  output size_e size_q,
  output logic  restart
);
  assign restart = fifo_req && (size_in != size_q);

  always_ff @(posedge clk) begin
    if (!rst_n)    size_q <= SZ_LONG;
    else if (take) size_q <= size_in;
  end

  assert_size_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (size_q == $past(size_in)));
endmodule

// File: rtl/bm_lane_accum.sv
module bm_lane_accum
  import bm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             restart,
  input  size_e            size_in,
  input  logic             be,
  input  long_t            din,
  output logic [CNT_W-1:0] cnt_q,
  output logic             is_last,
  output long_t            assembled
);
  long_t hold_q;
  long_t piece;
  long_t bits;
  long_t base;
  int    eff_idx;

  always_comb begin
    eff_idx   = restart ? 0 : int'(cnt_q);
    is_last   = (eff_idx == pieces_for(size_in) - 1);
    piece     = place_piece(din, size_in, be, eff_idx);
    bits      = expand_mask(piece_mask(size_in, be, eff_idx));
    base      = restart ? '0 : hold_q;
    assembled = (base & ~bits) | piece;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else if (take) begin
      if (is_last) begin
        cnt_q  <= '0;
        hold_q <= '0;
      end else begin
        cnt_q  <= CNT_W'(eff_idx + 1);
        hold_q <= assembled;
      end
    end
  end

  assert_clear_after_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_last) |=> (cnt_q == '0));
endmodule

// File: rtl/bm_write_packer.sv
module bm_write_packer
  import bm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  size_sel,
  input  logic        big_end,
  input  logic [1:0]  swap_sel,
  input  logic [35:0] wr_data,
  input  logic        fifo_full,
  output logic        accept,
  output logic        push,
  output logic [35:0] push_data,
  output logic        mbox_wr,
  output logic [35:0] mbox_data
);
  size_e            size_in;
  size_e            size_q;
  logic             fifo_req;
  logic             restart;
  logic             take;
  logic             is_last;
  logic             stall_final;
  logic [CNT_W-1:0] piece_cnt;
  long_t            assembled;

  assign size_in     = size_e'(size_sel);
  assign fifo_req    = wr_en && (size_in != SZ_MBOX);
  assign mbox_wr     = wr_en && (size_in == SZ_MBOX);
  assign stall_final = fifo_req && is_last && fifo_full;
  assign take        = fifo_req && !stall_final;
  assign accept      = mbox_wr || take;
  assign push        = take && is_last;
  assign push_data   = swap_lanes(assembled, swap_sel);
  assign mbox_data   = wr_data;

  bm_size_track u_size (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_req (fifo_req),
    .take     (take),
    .size_in  (size_in),
    .size_q   (size_q),
    .restart  (restart)
  );

  bm_lane_accum u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .restart   (restart),
    .size_in   (size_in),
    .be        (big_end),
    .din       (wr_data),
    .cnt_q     (piece_cnt),
    .is_last   (is_last),
    .assembled (assembled)
  );

  assert_no_push_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !fifo_full);

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_final |=> $stable(piece_cnt));

  assert_mbox_keeps_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_wr |=> $stable(piece_cnt));

  assert_restart_first_piece_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && restart && size_in != SZ_LONG) |=> (piece_cnt == CNT_W'(1)));

  assert_long_pushes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_req && size_in == SZ_LONG && !fifo_full) |-> push);

  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(piece_cnt) < pieces_for(size_q));
endmodule

// File: tb/sim_bm_write_packer.sv
module sim_bm_write_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  size_sel = 2'b00;
  logic        big_end = 1'b0;
  logic [1:0]  swap_sel = 2'b00;
  logic [35:0] wr_data = '0;
  logic        fifo_full = 1'b0;
  logic        accept, push, mbox_wr;
  logic [35:0] push_data, mbox_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  bm_write_packer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .size_sel(size_sel),
    .big_end(big_end), .swap_sel(swap_sel), .wr_data(wr_data),
    .fifo_full(fifo_full), .accept(accept), .push(push),
    .push_data(push_data), .mbox_wr(mbox_wr), .mbox_data(mbox_data)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        en;
    logic [1:0]  sz;
    logic        be;
    logic [1:0]  sw;
    logic        full;
    logic [35:0] din;
    logic        e_acc;
    logic        e_push;
    logic        e_mbox;
    logic [35:0] e_dat;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    // R1 long words, R8 reverse
    '{4'd1, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, {9'h101,9'h102,9'h103,9'h104}, 1'b1, 1'b1, 1'b0, {9'h101,9'h102,9'h103,9'h104}},
    '{4'd8, 1'b1, 2'd0, 1'b0, 2'd1, 1'b0, {9'h101,9'h102,9'h103,9'h104}, 1'b1, 1'b1, 1'b0, {9'h104,9'h103,9'h102,9'h101}},
    // R2 R4 R6 big-endian bytes with junk lanes
    '{4'd2, 1'b1, 2'd2, 1'b1, 2'd0, 1'b0, {9'h011,9'h1FF,9'h1FF,9'h1FF}, 1'b1, 1'b0, 1'b0, 36'h0},
    '{4'd2, 1'b1, 2'd2, 1'b1, 2'd0, 1'b0, {9'h022,9'h1FF,9'h1FF,9'h1FF}, 1'b1, 1'b0, 1'b0, 36'h0},
    '{4'd2, 1'b1, 2'd2, 1'b1, 2'd0, 1'b0, {9'h033,9'h1FF,9'h1FF,9'h1FF}, 1'b1, 1'b0, 1'b0, 36'h0},
    '{4'd4, 1'b1, 2'd2, 1'b1, 2'd0, 1'b0, {9'h044,9'h1FF,9'h1FF,9'h1FF}, 1'b1, 1'b1, 1'b0, {9'h011,9'h022,9'h033,9'h044}},
    // R3 little-endian word, R7 mailbox in between
    '{4'd3, 1'b1, 2'd1, 1'b0, 2'd0, 1'b0, {9'h1EE,9'h1EE,9'h056,9'h055}, 1'b1, 1'b0, 1'b0, 36'h0},
    '{4'd7, 1'b1, 2'd3, 1'b0, 2'd1, 1'b0, {9'h1AB,9'h1AC,9'h1AD,9'h1AE}, 1'b1, 1'b0, 1'b1, {9'h1AB,9'h1AC,9'h1AD,9'h1AE}},
    '{4'd7, 1'b1, 2'd1, 1'b0, 2'd2, 1'b0, {9'h1EE,9'h1EE,9'h058,9'h057}, 1'b1, 1'b1, 1'b0, {9'h056,9'h055,9'h058,9'h057}},
    // R4 big-endian word, R8 swap within halves
    '{4'd4, 1'b1, 2'd1, 1'b1, 2'd3, 1'b0, {9'h061,9'h062,9'h1EE,9'h1EE}, 1'b1, 1'b0, 1'b0, 36'h0},
    '{4'd8, 1'b1, 2'd1, 1'b1, 2'd3, 1'b0, {9'h063,9'h064,9'h1EE,9'h1EE}, 1'b1, 1'b1, 1'b0, {9'h062,9'h061,9'h064,9'h063}},
    // R5 partial bytes dropped by a size change
    '{4'd5, 1'b1, 2'd2, 1'b0, 2'd0, 1'b0, {9'h1FF,9'h1FF,9'h1FF,9'h071}, 1'b1, 1'b0, 1'b0, 36'h0},
    '{4'd5, 1'b1, 2'd2, 1'b0, 2'd0, 1'b0, {9'h1FF,9'h1FF,9'h1FF,9'h072}, 1'b1, 1'b0, 1'b0, 36'h0},
    '{4'd5, 1'b1, 2'd1, 1'b0, 2'd0, 1'b0, {9'h1EE,9'h1EE,9'h081,9'h082}, 1'b1, 1'b0, 1'b0, 36'h0},
    '{4'd5, 1'b1, 2'd1, 1'b0, 2'd0, 1'b0, {9'h1EE,9'h1EE,9'h083,9'h084}, 1'b1, 1'b1, 1'b0, {9'h083,9'h084,9'h081,9'h082}},
    // R9 full FIFO: early piece accepted, final piece refused then retried
    '{4'd9, 1'b1, 2'd2, 1'b0, 2'd0, 1'b1, {9'h1FF,9'h1FF,9'h1FF,9'h091}, 1'b1, 1'b0, 1'b0, 36'h0},
    '{4'd9, 1'b1, 2'd2, 1'b0, 2'd0, 1'b0, {9'h1FF,9'h1FF,9'h1FF,9'h092}, 1'b1, 1'b0, 1'b0, 36'h0},
    '{4'd9, 1'b1, 2'd2, 1'b0, 2'd0, 1'b0, {9'h1FF,9'h1FF,9'h1FF,9'h093}, 1'b1, 1'b0, 1'b0, 36'h0},
    '{4'd9, 1'b1, 2'd2, 1'b0, 2'd1, 1'b1, {9'h1FF,9'h1FF,9'h1FF,9'h094}, 1'b0, 1'b0, 1'b0, 36'h0},
    '{4'd9, 1'b1, 2'd2, 1'b0, 2'd1, 1'b0, {9'h1FF,9'h1FF,9'h1FF,9'h094}, 1'b1, 1'b1, 1'b0, {9'h091,9'h092,9'h093,9'h094}},
    // R10 idle
    '{4'd10, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 36'h0, 1'b0, 1'b0, 1'b0, 36'h0}
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic [1:0] sz, input logic be,
                       input logic [1:0] sw, input logic full, input logic [35:0] d);
    @(negedge clk);
    wr_en = en; size_sel = sz; big_end = be; swap_sel = sw; fifo_full = full; wr_data = d;
    #2;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    repeat (2) @(negedge clk);
    #2;
    chk(push == 1'b0 && accept == 1'b0 && mbox_wr == 1'b0, 10, "outputs in reset",
        {33'h0, push, accept, mbox_wr}, 36'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(push == 1'b0 && accept == 1'b0, 10, "outputs after reset",
        {34'h0, push, accept}, 36'h0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].en, TBL[i].sz, TBL[i].be, TBL[i].sw, TBL[i].full, TBL[i].din);
      chk(accept == TBL[i].e_acc, int'(TBL[i].req), $sformatf("row %0d accept", i),
          {35'h0, accept}, {35'h0, TBL[i].e_acc});
      chk(push == TBL[i].e_push, int'(TBL[i].req), $sformatf("row %0d push", i),
          {35'h0, push}, {35'h0, TBL[i].e_push});
      chk(mbox_wr == TBL[i].e_mbox, int'(TBL[i].req), $sformatf("row %0d mbox_wr", i),
          {35'h0, mbox_wr}, {35'h0, TBL[i].e_mbox});
      if (TBL[i].e_push)
        chk(push_data == TBL[i].e_dat, int'(TBL[i].req), $sformatf("row %0d push_data", i),
            push_data, TBL[i].e_dat);
      if (TBL[i].e_mbox)
        chk(mbox_data == TBL[i].e_dat, int'(TBL[i].req), $sformatf("row %0d mbox_data", i),
            mbox_data, TBL[i].e_dat);
    end

    // R10: reset in the middle of a byte word drops the first piece
    drive(1'b1, 2'd2, 1'b1, 2'd0, 1'b0, {9'h0A1, 27'h0});
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 2'd2, 1'b1, 2'd0, 1'b0, {9'h0A2, 27'h0});
    drive(1'b1, 2'd2, 1'b1, 2'd0, 1'b0, {9'h0A3, 27'h0});
    drive(1'b1, 2'd2, 1'b1, 2'd0, 1'b0, {9'h0A4, 27'h0});
    chk(push == 1'b0, 10, "third byte after reset must not push", {35'h0, push}, 36'h0);
    drive(1'b1, 2'd2, 1'b1, 2'd0, 1'b0, {9'h0A5, 27'h0});
    chk(push == 1'b1, 2, "fourth byte after reset pushes", {35'h0, push}, 36'h1);
    chk(push_data == {9'h0A2, 9'h0A3, 9'h0A4, 9'h0A5}, 2, "bytes after reset",
        push_data, {9'h0A2, 9'h0A3, 9'h0A4, 9'h0A5});

    // R1 long word while full is refused
    drive(1'b1, 2'd0, 1'b0, 2'd0, 1'b1, 36'h123456789);
    chk(push == 1'b0 && accept == 1'b0, 9, "long word while full",
        {34'h0, push, accept}, 36'h0);
    drive(1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 36'h123456789);
    chk(push_data == 36'h123456789, 1, "long word data", push_data, 36'h123456789);

    @(negedge clk);
    wr_en = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule